// File: doc/BRIEF.md
# Serial Programming Register Loader

This block is the programming port of a frequency synthesizer. A host sends a word over three wires: a data line, a serial clock and a latch strobe. On each rising edge of the serial clock, the data line is sampled into a 22-bit shift register. The most significant bit is sent first.

The last two bits of the word are a target code. The rising edge of the latch strobe moves the 20 payload bits above that code into one of three control registers. The fourth code is reserved and moves nothing. The three control registers drive the counters and the charge-pump logic downstream. A separate chip-enable input produces a power-down flag.

All three serial wires are synchronized into the system clock domain. Each wire's edges are found there, so the serial clock must be several system-clock periods slower than the system clock. Shifting runs all the time. Only the transfer waits for a new latch edge.

Top module: `syn_prog_loader`

## Requirements
- R1: While reset is asserted and right after it is released, `ctl_a`, `ctl_b` and `ctl_c` are all zero.
- R2: Each rising edge of `ser_clk` shifts `ser_dat` into the shift register, most significant bit first. Only the last 22 bits shifted before a latch count, so any earlier bits of a longer stream drop out.
- R3: On a latch, the word's bits [1:0] select the target: 0 selects `ctl_a`, 1 selects `ctl_b` and 2 selects `ctl_c`. The selected register receives word bits [21:2] unchanged, and the other two registers keep their values.
- R4: A latch whose target code is 3 changes none of the three registers.
- R5: A transfer happens once per rising edge of `ser_le`. While `ser_le` stays high, words shifted in afterwards are not loaded. The next rising edge loads the shift register's current contents.
- R6: Shifting bits in without a latch edge leaves all three registers unchanged.
- R7: `pwr_down` is the inverse of `chip_en` with no clock delay, including during reset. Words are still accepted while `pwr_down` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Latch strobe; its rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low requests power-down |
| ctl_a | output | 20 | Control register for target code 0 |
| ctl_b | output | 20 | Control register for target code 1 |
| ctl_c | output | 20 | Control register for target code 2 |
| pwr_down | output | 1 | Power-down flag |

## Verification
The hardest case to reach is a latch strobe that stays high while a new word is shifted in behind it. A design that reloads on the level of the strobe, rather than on its edge, looks correct under ordinary pulsed latches. The stimulus therefore raises the strobe after one word and keeps it high while a different word for the same target is clocked in. It checks that the register still holds the first word, then lowers and raises the strobe and expects the second word. A stream with leading surplus bits checks that only the final 22 bits are used.

// File: rtl/syn_prog_pkg.sv
package syn_prog_pkg;
   localparam int unsigned ADDR_W  = 2;
   localparam int unsigned NUM_TGT = 3;
   typedef enum logic [ADDR_W-1:0] {
      TGT_A   = 2'd0,
      TGT_B   = 2'd1,
      TGT_C   = 2'd2,
      TGT_RSV = 2'd3
   } tgt_e;
endpackage

// File: rtl/syn_edge_sync.sv
module syn_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q,
   output logic rise
);
   if (STAGES < 1) begin : g_bad_stages
      $error("syn_edge_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] pipe;
   logic              prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[s] <= 1'b0;
            else        pipe[s] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[s] <= 1'b0;
            else        pipe[s] <= pipe[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= pipe[STAGES-1];

   assign q    = pipe[STAGES-1];
   assign rise = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/syn_shift_reg.sv
module syn_shift_reg #(
   parameter int unsigned WIDTH = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 2) begin : g_bad_width
      $error("syn_shift_reg: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= {q[WIDTH-2:0], din};
endmodule

// File: rtl/syn_reg_bank.sv
module syn_reg_bank import syn_prog_pkg::*; #(
   parameter int unsigned PAY_W = 20,
   parameter int unsigned NUM   = NUM_TGT
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [PAY_W-1:0]          payload,
   output logic [NUM-1:0][PAY_W-1:0] regs
);
   if (NUM > (1 << ADDR_W)) begin : g_bad_num
      $error("syn_reg_bank: more targets than address codes");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_tgt
      logic hit;
      assign hit = load && (addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)   regs[i] <= '0;
         else if (hit) regs[i] <= payload;
   end
endmodule

// File: rtl/syn_prog_loader.sv
module syn_prog_loader import syn_prog_pkg::*; #(
   parameter int unsigned WORD_W      = 22,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_clk,
   input  logic                     ser_dat,
   input  logic                     ser_le,
   input  logic                     chip_en,
   output logic [WORD_W-ADDR_W-1:0] ctl_a,
   output logic [WORD_W-ADDR_W-1:0] ctl_b,
   output logic [WORD_W-ADDR_W-1:0] ctl_c,
   output logic                     pwr_down
);
   localparam int unsigned PAY_W = WORD_W - ADDR_W;

   if (WORD_W <= ADDR_W) begin : g_bad_word
      $error("syn_prog_loader: WORD_W must exceed the address width");
   end

   logic              clk_rise, le_rise, dat_s, clk_s, le_s;
   logic [WORD_W-1:0] word;
   logic [NUM_TGT-1:0][PAY_W-1:0] regs;

   syn_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk (
      .clk(clk), .rst_n(rst_n), .din(ser_clk), .q(clk_s), .rise(clk_rise));
   syn_edge_sync #(.STAGES(SYNC_STAGES)) u_sle (
      .clk(clk), .rst_n(rst_n), .din(ser_le), .q(le_s), .rise(le_rise));

   // Data passes through the same depth of flops as the serial clock, so the
   // sampled bit lines up with the detected edge.
   logic dat_rise_unused;
   syn_edge_sync #(.STAGES(SYNC_STAGES)) u_sdat (
      .clk(clk), .rst_n(rst_n), .din(ser_dat), .q(dat_s), .rise(dat_rise_unused));

   syn_shift_reg #(.WIDTH(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .din(dat_s), .q(word));

   syn_reg_bank #(.PAY_W(PAY_W), .NUM(NUM_TGT)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(le_rise),
      .addr(word[ADDR_W-1:0]), .payload(word[WORD_W-1:ADDR_W]), .regs(regs));

   assign ctl_a    = regs[0];
   assign ctl_b    = regs[1];
   assign ctl_c    = regs[2];
   assign pwr_down = ~chip_en;

   logic unused_ok;
   assign unused_ok = &{1'b0, clk_s, le_s, dat_rise_unused};
endmodule

// File: rtl/syn_prog_chk.sv
module syn_prog_chk #(
   parameter int unsigned WORD_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_rise,
   input logic              le_rise,
   input logic [WORD_W-1:0] word,
   input logic [WORD_W-3:0] ctl_a,
   input logic [WORD_W-3:0] ctl_b,
   input logic [WORD_W-3:0] ctl_c
);
   p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_rise |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0]));
   p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_rise |=> $stable(word));
   p_load_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && word[1:0] == 2'd0) |=> ctl_a == $past(word[WORD_W-1:2]) && $stable(ctl_b) && $stable(ctl_c));
   p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && word[1:0] == 2'd1) |=> ctl_b == $past(word[WORD_W-1:2]) && $stable(ctl_a) && $stable(ctl_c));
   p_load_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && word[1:0] == 2'd2) |=> ctl_c == $past(word[WORD_W-1:2]) && $stable(ctl_a) && $stable(ctl_b));
   p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && word[1:0] == 2'd3) |=> $stable(ctl_a) && $stable(ctl_b) && $stable(ctl_c));
   p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise |=> !le_rise);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> $stable(ctl_a) && $stable(ctl_b) && $stable(ctl_c));
endmodule

bind syn_prog_loader syn_prog_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .le_rise(le_rise),
   .word(word), .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_c(ctl_c));

// File: tb/sim_syn_prog_loader.sv
module sim_syn_prog_loader;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
   logic [19:0] ctl_a, ctl_b, ctl_c;
   logic pwr_down;
   logic [19:0] exp_r [3];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   syn_prog_loader u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .chip_en(chip_en), .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_c(ctl_c),
      .pwr_down(pwr_down));

   task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, ctl_a, exp_r[0]);
      chk(req, ctl_b, exp_r[1]);
      chk(req, ctl_c, exp_r[2]);
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b; waitn(4);
      ser_clk = 1'b1; waitn(4);
      ser_clk = 1'b0; waitn(4);
   endtask

   task automatic send_word(input logic [21:0] w);
      for (int i = 21; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic latch_pulse();
      ser_le = 1'b1; waitn(5);
      ser_le = 1'b0; waitn(6);
   endtask

   function automatic logic [19:0] pat(input int k);
      logic [31:0] t;
      if (k == 0) return 20'h00000;
      if (k == 1) return 20'hFFFFF;
      if (k == 2) return 20'h80001;
      t = 32'h9E3779B9 * 32'(k + 3);
      return t[26:7];
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) exp_r[i] = '0;
      // R7 during reset
      chip_en = 1'b0; #1;
      chk("R7 pwr_down in reset", {19'd0, pwr_down}, 20'd1);
      chip_en = 1'b1; #1;
      chk("R7 pwr_down in reset", {19'd0, pwr_down}, 20'd0);
      waitn(3);
      chk_all("R1 reset value");
      rst_n = 1'b1;
      waitn(3);
      chk_all("R1 after reset release");

      // R3/R4 sweep over all target codes and several payloads
      for (int k = 0; k < 6; k++) begin
         for (int a = 0; a < 4; a++) begin
            logic [19:0] p;
            p = pat(k * 4 + a);
            send_word({p, 2'(a)});
            if (a < 3) exp_r[a] = p;
            latch_pulse();
            chk_all(a == 3 ? "R4 reserved code" : "R3 targeted load");
         end
      end

      // R6 shift without latch
      send_word({20'h13579, 2'd1});
      waitn(6);
      chk_all("R6 no latch edge");

      // R2 long stream: surplus leading bits drop out
      for (int i = 0; i < 7; i++) send_bit(i[0]);
      send_word({20'hC0DE5, 2'd2});
      exp_r[2] = 20'hC0DE5;
      latch_pulse();
      chk_all("R2 last 22 bits used");

      // R5 latch held high
      send_word({20'h2468A, 2'd0});
      ser_le = 1'b1; waitn(6);
      exp_r[0] = 20'h2468A;
      chk_all("R5 first load");
      send_word({20'hBEEF1, 2'd0});
      waitn(6);
      chk_all("R5 held high no reload");
      ser_le = 1'b0; waitn(5);
      ser_le = 1'b1; waitn(6);
      exp_r[0] = 20'hBEEF1;
      chk_all("R5 new edge loads");
      ser_le = 1'b0; waitn(5);

      // R7 programming during power-down
      chip_en = 1'b0; waitn(1);
      chk("R7 pwr_down high", {19'd0, pwr_down}, 20'd1);
      send_word({20'h0F0F0, 2'd1});
      exp_r[1] = 20'h0F0F0;
      latch_pulse();
      chk_all("R7 load while powered down");
      chip_en = 1'b1; #1;
      chk("R7 pwr_down low", {19'd0, pwr_down}, 20'd0);

      done = 1;
      finish_run();
   end
endmodule